// File: doc/BRIEF.md
# Interlaced Raster Timing Generator with Bitmap Overlay

This block produces the timing for a 625-line, two-field interlaced monitor from a fast system clock. A fractional divider turns the system clock into a pixel enable (two enables in every five clocks, so an 80 MHz clock yields 32 MHz). A horizontal counter and a frame line counter advance on that enable. Comparators at parameter-set counts produce composite sync, composite blanking, the active pixel position, the field flag and the source image row.

Software sets the first visible line of each field through an input port, which centres the picture vertically. Inside the active area, every output sample is either the stored image pixel or a fixed overlay level. A one-bit map decides which one. The map sits in an on-chip dual-port RAM: a host writes it, and the block reads it one pixel ahead so that its bit arrives together with the pixel position. Outside active video the DAC word is held at black.

Top module: `pal_raster_overlay`

## Requirements
- R1: `pix_ce` is high on exactly CE_NUM of every CE_DEN clocks. With the defaults of 2 and 5, the pattern after reset is 0,0,1,0,1, repeating. All outputs except `pix_ce` and `dac_out` are registers that update only on clocks where `pix_ce` is high.
- R2: A line lasts H_TOTAL enables and a frame lasts FRAME_LINES lines, which must be an odd number. Outside vertical sync, `csync_n` is low for the HS_W enables that start at horizontal count HS_START.
- R3: `blank` is low only when the horizontal count lies in [HA_START, HA_START+H_ACTIVE) and the line is active. While `blank` is low, `act_x` equals the horizontal count minus HA_START. While `blank` is high, `act_x` and `act_y` read 0.
- R4: The first field holds frame lines 0 to (FRAME_LINES-1)/2, and the second field numbers its lines from (FRAME_LINES+1)/2. A line is active when its in-field index is in [v_start, v_start+ACT_LINES). `act_y` is that index minus `v_start`. A change to `v_start` applies from the next enable.
- R5: `field` is 0 in the first half of the frame and rises at the middle of line (FRAME_LINES-1)/2, at horizontal count H_TOTAL/2. It falls at the start of the frame.
- R6: Vertical sync spans the first 2·VS_LINES half-lines of each field. During vertical sync, `csync_n` is the inverse of the horizontal-sync level it would otherwise have (XOR composite).
- R7: `src_row` equals 2·`act_y` + `field`, so one field shows the even source rows and the other shows the odd rows.
- R8: In the overlay window, the map bit at address `act_y`·OVL_W + `act_x` selects the output. A bit of 1 drives `dac_out` to CHAR_LVL. A bit of 0 passes `pix_in` through.
- R9: While `blank` is high, `dac_out` equals BLACK whatever `pix_in` holds.
- R10: Active pixels with `act_x` ≥ OVL_W or `act_y` ≥ OVL_H always show `pix_in`.
- R11: Between enables, all registered outputs hold their values.
- R12: While `rst` is high: `blank`=1, `csync_n`=1, `field`=0, `act_x`=`act_y`=0, `pix_ce`=0 and `dac_out`=BLACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| v_start | input | $clog2(FRAME_LINES) | First active line index within each field |
| pix_in | input | DW | Image pixel for the current `act_x`/`src_row` |
| ovl_we | input | 1 | Overlay map write enable |
| ovl_waddr | input | log2(OVL_W·OVL_H) | Overlay map write address (row·OVL_W + column) |
| ovl_wbit | input | 1 | Overlay map write data |
| pix_ce | output | 1 | Pixel enable |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Composite blanking, high outside active video |
| field | output | 1 | Field flag |
| act_x | output | $clog2(H_ACTIVE) | Active pixel column |
| act_y | output | $clog2(ACT_LINES) | Active line within the field |
| src_row | output | $clog2(ACT_LINES)+1 | Source image row to fetch |
| dac_out | output | DW | Sample to the video DAC |

## Verification
The bench concentrates on three kinds of boundary. The first is the half-line boundary: a design that flips the field at the start of a line would move `field`, `src_row` and the second vertical-sync burst half a line early. The second is the vertical window when `v_start` changes in mid-frame: an off-by-one there shifts `act_y` and unblanks one line too many or too few. The third is the overlay timing: a map read issued one pixel late shows the character shifted right, and a missing window test repeats the map across the whole picture. The bench also rewrites the map while video runs and feeds random pixels during blanking, which exposes any leakage of image data into black.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // flags decoded from the counters for one pixel slot
   typedef struct packed {
      logic hsync;
      logic vsync;
      logic act;
      logic win;
      logic field;
   } raster_flags_t;
endpackage

// File: rtl/pal_ce_gen.sv
module pal_ce_gen #(
   parameter int CE_NUM = 2,
   parameter int CE_DEN = 5,
   localparam int AW = $clog2(CE_NUM + CE_DEN) + 1
) (
   input  logic clk,
   input  logic rst,
   output logic ce
);
   if (CE_NUM < 1 || CE_NUM > CE_DEN) begin : g_bad_ratio
      $error("pal_ce_gen: CE_NUM must be in 1..CE_DEN");
   end

   if (CE_NUM == CE_DEN) begin : g_full_rate
      assign ce = !rst;
   end else begin : g_frac
      logic [AW-1:0] acc;
      logic [AW-1:0] sum;
      always_comb begin
         sum = acc + AW'(CE_NUM);
         ce  = (sum >= AW'(CE_DEN));
      end
      always_ff @(posedge clk) begin
         if (rst)     acc <= '0;
         else if (ce) acc <= sum - AW'(CE_DEN);
         else         acc <= sum;
      end
      if (2 * CE_NUM <= CE_DEN) begin : g_gap
         // R1
         ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
            ce |=> !ce);
      end
   end
endmodule

// File: rtl/pal_raster_cnt.sv
module pal_raster_cnt #(
   parameter int H_TOTAL     = 2048,
   parameter int FRAME_LINES = 625,
   localparam int HW = $clog2(H_TOTAL),
   localparam int LW = $clog2(FRAME_LINES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   output logic [HW-1:0] h_cnt,
   output logic [LW-1:0] l_cnt
);
   always_ff @(posedge clk) begin
      if (rst) begin
         h_cnt <= '0;
         l_cnt <= '0;
      end else if (ce) begin
         if (h_cnt == HW'(H_TOTAL - 1)) begin
            h_cnt <= '0;
            l_cnt <= (l_cnt == LW'(FRAME_LINES - 1)) ? '0 : l_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   // R2
   hwrap_chk: assert property (@(posedge clk) disable iff (rst)
      (ce && h_cnt == HW'(H_TOTAL - 1)) |=> (h_cnt == '0));
endmodule

// File: rtl/pal_ovl_ram.sv
module pal_ovl_ram #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);
   logic mem [2**AW];
   // read sees the old contents on an address collision
   always_ff @(posedge clk) begin
      if (re) rbit <= mem[raddr];
      if (we) mem[waddr] <= wbit;
   end
endmodule

// File: rtl/pal_raster_overlay.sv
module pal_raster_overlay
   import pal_pkg::*;
#(
   parameter int CE_NUM      = 2,
   parameter int CE_DEN      = 5,
   parameter int H_TOTAL     = 2048,
   parameter int H_ACTIVE    = 1400,
   parameter int HA_START    = 560,
   parameter int HS_START    = 48,
   parameter int HS_W        = 150,
   parameter int FRAME_LINES = 625,
   parameter int ACT_LINES   = 288,
   parameter int VS_LINES    = 3,
   parameter int OVL_W       = 64,
   parameter int OVL_H       = 32,
   parameter int DW          = 10,
   parameter int BLACK       = 64,
   parameter int CHAR_LVL    = 940,
   localparam int LW = $clog2(FRAME_LINES),
   localparam int XW = $clog2(H_ACTIVE),
   localparam int YW = $clog2(ACT_LINES),
   localparam int OX = $clog2(OVL_W),
   localparam int OY = $clog2(OVL_H),
   localparam int OA = OX + OY
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [LW-1:0] v_start,
   input  logic [DW-1:0] pix_in,
   input  logic          ovl_we,
   input  logic [OA-1:0] ovl_waddr,
   input  logic          ovl_wbit,
   output logic          pix_ce,
   output logic          csync_n,
   output logic          blank,
   output logic          field,
   output logic [XW-1:0] act_x,
   output logic [YW-1:0] act_y,
   output logic [YW:0]   src_row,
   output logic [DW-1:0] dac_out
);
   localparam int HW      = $clog2(H_TOTAL);
   localparam int HALF    = H_TOTAL / 2;
   localparam int F1_BASE = (FRAME_LINES + 1) / 2;

   if (FRAME_LINES % 2 == 0 || H_TOTAL % 2 != 0) begin : g_bad_frame
      $error("pal_raster_overlay: FRAME_LINES must be odd and H_TOTAL even");
   end
   if (HA_START + H_ACTIVE > H_TOTAL || HS_START + HS_W > H_TOTAL) begin : g_bad_h
      $error("pal_raster_overlay: horizontal windows exceed the line");
   end
   if (OVL_W > H_ACTIVE || OVL_H > ACT_LINES || OVL_W < 2 || OVL_H < 2
       || (1 << OX) != OVL_W || (1 << OY) != OVL_H) begin : g_bad_ovl
      $error("pal_raster_overlay: overlay window must be a power-of-two fit");
   end
   if (4 * VS_LINES >= FRAME_LINES || 2 * ACT_LINES >= FRAME_LINES) begin : g_bad_v
      $error("pal_raster_overlay: vertical sizes exceed a field");
   end

   logic [HW-1:0] h_cnt;
   logic [LW-1:0] l_cnt;

   pal_ce_gen #(.CE_NUM(CE_NUM), .CE_DEN(CE_DEN)) u_ce (
      .clk(clk), .rst(rst), .ce(pix_ce));

   pal_raster_cnt #(.H_TOTAL(H_TOTAL), .FRAME_LINES(FRAME_LINES)) u_cnt (
      .clk(clk), .rst(rst), .ce(pix_ce), .h_cnt(h_cnt), .l_cnt(l_cnt));

   // decode of the slot currently addressed by the counters
   raster_flags_t fl;
   logic [31:0]   h32, l32, v32, hl32, fl32, x32, y32;
   logic [OA-1:0] rd_addr;
   always_comb begin
      h32      = 32'(h_cnt);
      l32      = 32'(l_cnt);
      v32      = 32'(v_start);
      hl32     = (l32 << 1) + ((h32 >= 32'(HALF)) ? 32'd1 : 32'd0);
      fl.field = (hl32 >= 32'(FRAME_LINES));
      fl.vsync = (hl32 < 32'(2 * VS_LINES))
               || (fl.field && hl32 < 32'(FRAME_LINES + 2 * VS_LINES));
      fl.hsync = (h32 >= 32'(HS_START)) && (h32 < 32'(HS_START + HS_W));
      fl32     = fl.field ? l32 - 32'(F1_BASE) : l32;
      fl.act   = (h32 >= 32'(HA_START)) && (h32 < 32'(HA_START + H_ACTIVE))
               && (fl32 >= v32) && (fl32 < v32 + 32'(ACT_LINES));
      x32      = h32 - 32'(HA_START);
      y32      = fl32 - v32;
      fl.win   = fl.act && (x32 < 32'(OVL_W)) && (y32 < 32'(OVL_H));
      rd_addr  = {y32[OY-1:0], x32[OX-1:0]};
   end

   // map read issued in the same enable as the position register
   logic ovl_bit;
   pal_ovl_ram #(.AW(OA)) u_ram (
      .clk(clk), .we(ovl_we), .waddr(ovl_waddr), .wbit(ovl_wbit),
      .re(pix_ce), .raddr(rd_addr), .rbit(ovl_bit));

   logic blank_q, csync_q, field_q, win_q;
   logic [XW-1:0] x_q;
   logic [YW-1:0] y_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         blank_q <= 1'b1;
         csync_q <= 1'b1;
         field_q <= 1'b0;
         win_q   <= 1'b0;
         x_q     <= '0;
         y_q     <= '0;
      end else if (pix_ce) begin
         blank_q <= !fl.act;
         csync_q <= !(fl.hsync ^ fl.vsync);
         field_q <= fl.field;
         win_q   <= fl.win;
         x_q     <= fl.act ? x32[XW-1:0] : '0;
         y_q     <= fl.act ? y32[YW-1:0] : '0;
      end
   end

   logic show_char;
   assign show_char = win_q & ovl_bit;
   assign blank     = blank_q;
   assign csync_n   = csync_q;
   assign field     = field_q;
   assign act_x     = x_q;
   assign act_y     = y_q;
   assign src_row   = {y_q, field_q};
   assign dac_out   = blank_q ? DW'(BLACK) : (show_char ? DW'(CHAR_LVL) : pix_in);

   // R5
   field_mid_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(field_q) |-> ($past(h_cnt) == HW'(HALF) || $past(h_cnt) == '0));
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(pix_ce) |-> ($stable(blank_q) && $stable(x_q) && $stable(csync_q)));
endmodule

// File: tb/pal_raster_overlay_bench.sv
`timescale 1ns/1ps
module pal_raster_overlay_bench;
   localparam int HT = 32, HACT = 16, HAS = 12, HSS = 2, HSW = 4;
   localparam int FL = 21, AL = 6, VSL = 2, OW = 8, OH = 4;
   localparam int BLK = 64, CHR = 940, NCYC = 6000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] v_start = 5'd3;
   logic [9:0] pix_in = '0;
   logic       ovl_we = 1'b0;
   logic [4:0] ovl_waddr = '0;
   logic       ovl_wbit = 1'b0;
   logic       pix_ce, csync_n, blank, field;
   logic [3:0] act_x;
   logic [2:0] act_y;
   logic [3:0] src_row;
   logic [9:0] dac_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pal_raster_overlay #(
      .CE_NUM(2), .CE_DEN(5), .H_TOTAL(HT), .H_ACTIVE(HACT), .HA_START(HAS),
      .HS_START(HSS), .HS_W(HSW), .FRAME_LINES(FL), .ACT_LINES(AL),
      .VS_LINES(VSL), .OVL_W(OW), .OVL_H(OH), .DW(10), .BLACK(BLK),
      .CHAR_LVL(CHR)
   ) u_pal_raster_overlay (
      .clk(clk), .rst(rst), .v_start(v_start), .pix_in(pix_in),
      .ovl_we(ovl_we), .ovl_waddr(ovl_waddr), .ovl_wbit(ovl_wbit),
      .pix_ce(pix_ce), .csync_n(csync_n), .blank(blank), .field(field),
      .act_x(act_x), .act_y(act_y), .src_row(src_row), .dac_out(dac_out));

   // behavioural reference, advanced at each rising edge
   int acc = 0, mh = 0, ml = 0, e_x = 0, e_y = 0;
   bit e_blank = 1, e_cs = 1, e_fld = 0, e_win = 0, e_ovl = 0, e_vs = 0;
   bit last_ce = 0, m_rst = 1;
   bit mem [32];

   always @(posedge clk) begin : model
      bit ce, fld, vs, hs, act, win;
      int hl, fline, x, y;
      m_rst = rst;
      if (rst) begin
         acc = 0; mh = 0; ml = 0; e_x = 0; e_y = 0;
         e_blank = 1; e_cs = 1; e_fld = 0; e_win = 0; e_ovl = 0; e_vs = 0;
         last_ce = 0;
      end else begin
         ce = (acc + 2 >= 5);
         acc = ce ? acc - 3 : acc + 2;
         last_ce = ce;
         if (ce) begin
            hl    = 2 * ml + ((mh >= HT / 2) ? 1 : 0);
            fld   = (hl >= FL);
            vs    = (hl < 2 * VSL) || (fld && hl < FL + 2 * VSL);
            hs    = (mh >= HSS) && (mh < HSS + HSW);
            fline = fld ? ml - (FL + 1) / 2 : ml;
            act   = (mh >= HAS) && (mh < HAS + HACT)
                    && (fline >= int'(v_start)) && (fline < int'(v_start) + AL);
            x     = mh - HAS;
            y     = fline - int'(v_start);
            win   = act && x < OW && y < OH;
            e_ovl   = win ? mem[y * OW + x] : 1'b0;
            e_blank = !act;
            e_cs    = !(hs ^ vs);
            e_vs    = vs;
            e_fld   = fld;
            e_win   = win;
            e_x     = act ? x : 0;
            e_y     = act ? y : 0;
            if (mh == HT - 1) begin
               mh = 0;
               ml = (ml == FL - 1) ? 0 : ml + 1;
            end else begin
               mh = mh + 1;
            end
         end
      end
      if (ovl_we) mem[ovl_waddr] = ovl_wbit;
   end

   task automatic chk(input string tag, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act_v, exp_v);
      end
   endtask

   task automatic compare_all();
      string t;
      int e_dac;
      chk("R1 pix_ce", int'(pix_ce), (acc + 2 >= 5) ? 1 : 0);
      if (m_rst)        t = "R12";
      else if (!last_ce) t = "R11";
      else              t = "";
      chk((t != "") ? t : (e_vs ? "R6 csync" : "R2 csync"), int'(csync_n), int'(e_cs));
      chk((t != "") ? t : "R3 blank", int'(blank), int'(e_blank));
      chk((t != "") ? t : "R3 act_x", int'(act_x), e_x);
      chk((t != "") ? t : "R4 act_y", int'(act_y), e_y);
      chk((t != "") ? t : "R5 field", int'(field), int'(e_fld));
      chk((t != "") ? t : "R7 src_row", int'(src_row), 2 * e_y + int'(e_fld));
      e_dac = e_blank ? BLK : (e_ovl ? CHR : int'(pix_in));
      if (m_rst)        t = "R12 dac";
      else if (e_blank) t = "R9 dac";
      else if (e_win)   t = "R8 dac";
      else              t = "R10 dac";
      chk(t, int'(dac_out), e_dac);
   endtask

   initial begin
      for (int c = 0; c < NCYC; c++) begin
         @(negedge clk);
         rst = (c < 5);
         if (c < 32) begin
            ovl_we = 1'b1; ovl_waddr = 5'(c); ovl_wbit = ((c * 7) % 3 == 0);
         end else if (c >= 3000 && c < 3032) begin
            ovl_we = 1'b1; ovl_waddr = 5'(c - 3000); ovl_wbit = ((c * 7) % 3 != 0);
         end else begin
            ovl_we = 1'b0;
         end
         v_start = (c < 2200) ? 5'd3 : ((c < 4000) ? 5'd1 : 5'd4);
         pix_in  = 10'($urandom);
         #1;
         compare_all();
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule